// File: doc/BRIEF.md
# Video Capture Frame-Synchronous Status and Base Shadow Block

This block sits in the control path of a video capture port. Software programs new frame-buffer base addresses through a small register port. Each write goes into a staging copy, and the block holds it as pending. The capture engine only ever sees the active copies. Pending values move into the active copies at a start-of-frame event. That event is the first cycle of vertical blanking, and in interlaced operation it must also fall in the odd field. Because the active copies come out of reset at zero, software waits for the pending flag to clear before it enables capture.

The same 32-bit status word, at byte offset 08h, also reports three more things:
- an 8-bit ancillary packet count, which hardware raises on each received packet and software lowers through a write strobe;
- three per-FIFO pointer-misalignment flags, taken at every start-of-frame, whose newly set bits raise an interrupt;
- a write strobe that sends a fixed-width high pulse on the sync pin.

Top module: `vcap_status`

## Requirements
- R1: The status word is read at address 08h. Bits [31:24] hold the packet count. Bits [22:20] hold the FIFO error flags. Bit 16 is the pending flag. Every other bit, including the write strobes at bits 18 and 17, reads 0. A read of an unmapped address returns 0.
- R2: A write to base register i (address 10h + 4*i) updates its staging copy, which reads back at that address. The write leaves the active output unchanged and sets status bit 16.
- R3: In progressive mode (interlaced = 0), a rising edge of vblank copies every pending staging value into the active outputs and clears bit 16 on the next read.
- R4: In interlaced mode, the copy happens only when field_odd is 1 in the cycle vblank rises. A rise in the even field transfers nothing. Holding vblank high produces no further event.
- R5: A base write in the same cycle as a start-of-frame event stays pending. The active output takes the value staged before that write, and the new value moves across at the next event.
- R6: After reset, all active bases are 0, the status word is 0, and irq and sync_out are 0.
- R7: Each pkt_rcvd cycle adds 1 to the count. A status write with bit 18 set subtracts 1. When both happen in the same cycle, the count is unchanged.
- R8: The count saturates at 255 and at 0 instead of wrapping.
- R9: At every start-of-frame event, the error flags load fifo_misalign[2:0] (B on bit 22, R on bit 21, Y on bit 20) when vbi_en is 0, and load 0 when vbi_en is 1. They hold their value between events.
- R10: irq is high for exactly the one cycle in which an error flag changes from 0 to 1. It stays low when the flags reload with the same set bits.
- R11: A status write with bit 17 set drives sync_out high for exactly 32 cycles and then low. A second such write during the pulse is ignored and does not lengthen it.
- R12: Writes to the read-only status fields (bits 31:24, 22:20, 16) change neither the count nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| interlaced | input | 1 | 1 = interlaced video, 0 = progressive |
| field_odd | input | 1 | Current field is odd |
| vblank | input | 1 | Vertical blanking indication |
| vbi_en | input | 1 | Vertical-blanking-data reception enabled |
| pkt_rcvd | input | 1 | One-cycle strobe per ancillary packet |
| fifo_misalign | input | 3 | Per-FIFO misalignment: [2] B, [1] R, [0] Y |
| active_base | output | 128 | Active base addresses, base i at [32*i +: 32] |
| irq | output | 1 | Error-flag interrupt pulse |
| sync_out | output | 1 | Sync pulse output |

## Verification
The bench goes after the start-of-frame qualification. An even-field blanking edge, a long-held blanking level and a base write landing in the same cycle as an event each expose a design that transfers too often or loses the newer value. It drives the counter into both saturation limits and issues simultaneous increment and decrement; a design that wrapped or let one side win would show 0, 255 or a one-off count. It retriggers the sync strobe mid-pulse, which catches a pulse that restarts and runs longer than 32 cycles. It reloads identical error flags, so a level-driven interrupt would show up as a spurious irq.

// File: rtl/vcap_status_pkg.sv
// Package: register offsets and status-word bit positions shared by the
// capture status block and its checker. Assumes byte addressing with 32-bit
// registers.
package vcap_status_pkg;
    localparam int REG_AW   = 8;
    localparam int REG_DW   = 32;
    localparam logic [REG_AW-1:0] STATUS_OFS = 8'h08;
    localparam logic [REG_AW-1:0] BASE_OFS   = 8'h10;
    localparam int CNT_LSB  = 24;
    localparam int FPE_LSB  = 20;
    localparam int DEC_BIT  = 18;
    localparam int SYNC_BIT = 17;
    localparam int PEND_BIT = 16;
    localparam int NUM_FIFO = 3;
endpackage

// File: rtl/vcap_base_shadow.sv
// Module: staging/active pairs for the frame buffer base addresses.
// Each write lands in staging and marks the entry pending. A start-of-frame
// pulse copies pending entries to active. A write in the same cycle as
// start-of-frame wins the pending bit, so its value waits for the next event.
// Assumes wr_en is already address-decoded and one-hot or zero.
module vcap_base_shadow #(
    parameter int NUM_BASES = 4,
    parameter int BASE_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BASES-1:0]        wr_en,
    input  logic [BASE_W-1:0]           wdata,
    input  logic                        sof,
    output logic [NUM_BASES*BASE_W-1:0] staged_flat,
    output logic [NUM_BASES*BASE_W-1:0] active_flat,
    output logic [NUM_BASES-1:0]        pending
);
    for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
        logic [BASE_W-1:0] stage_q;
        logic [BASE_W-1:0] active_q;
        logic              pend_q;

        // Staging copy follows software writes.
        always_ff @(posedge clk) begin
            if (!rst_n)       stage_q <= '0;
            else if (wr_en[g]) stage_q <= wdata;
        end

        // Pending bit: set by a write, cleared by start-of-frame.
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_q <= 1'b0;
            else if (wr_en[g]) pend_q <= 1'b1;
            else if (sof)      pend_q <= 1'b0;
        end

        // Active copy loads the pre-write staging value at start-of-frame.
        always_ff @(posedge clk) begin
            if (!rst_n)            active_q <= '0;
            else if (sof && pend_q) active_q <= stage_q;
        end

        assign staged_flat[g*BASE_W +: BASE_W] = stage_q;
        assign active_flat[g*BASE_W +: BASE_W] = active_q;
        assign pending[g] = pend_q;
    end
endmodule

// File: rtl/vcap_pkt_counter.sv
// Module: saturating up/down packet counter.
// Increment and decrement in the same cycle cancel. Saturates at all-ones
// and at zero. Assumes both inputs are single-cycle strobes.
module vcap_pkt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Counter update with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && !dec && count != CNT_MAX)
            count <= count + 1'b1;
        else if (dec && !inc && count != '0)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/vcap_sync_pulse.sv
// Module: fixed-width pulse generator for the sync pin.
// A start request while idle drives the output high for PULSE_LEN cycles.
// Requests made during a pulse are dropped. Assumes PULSE_LEN >= 2.
module vcap_sync_pulse #(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_LEN);
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    logic [CW-1:0] left_q;

    // Busy flag and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            left_q <= '0;
        end else if (!pulse) begin
            if (start) begin
                pulse  <= 1'b1;
                left_q <= LAST;
            end
        end else if (left_q == '0) begin
            pulse <= 1'b0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/vcap_status.sv
// Module: capture-port status word and frame-synchronous base update.
// Decodes the register port, detects start-of-frame as a rising vblank edge
// (odd field only when interlaced), samples the FIFO error flags at each
// event and pulses irq on newly set flags. Assumes vblank, field_odd and
// fifo_misalign are already synchronous to clk.
module vcap_status
    import vcap_status_pkg::*;
#(
    parameter int NUM_BASES = 4,
    parameter int BASE_W    = 32,
    parameter int CNT_W     = 8,
    parameter int SYNC_LEN  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wen,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [REG_DW-1:0]           reg_wdata,
    output logic [REG_DW-1:0]           reg_rdata,
    input  logic                        interlaced,
    input  logic                        field_odd,
    input  logic                        vblank,
    input  logic                        vbi_en,
    input  logic                        pkt_rcvd,
    input  logic [NUM_FIFO-1:0]         fifo_misalign,
    output logic [NUM_BASES*BASE_W-1:0] active_base,
    output logic                        irq,
    output logic                        sync_out
);
    logic                        stat_wr;
    logic                        dec_req;
    logic                        sync_req;
    logic [NUM_BASES-1:0]        base_wr;
    logic                        vblank_q;
    logic                        sof_evt;
    logic [NUM_FIFO-1:0]         fpe_q;
    logic [NUM_FIFO-1:0]         fpe_next;
    logic [NUM_BASES-1:0]        pending;
    logic                        brnu;
    logic [CNT_W-1:0]            pkt_cnt;
    logic [NUM_BASES*BASE_W-1:0] staged;
    logic [REG_DW-1:0]           status_word;

    assign stat_wr  = reg_wen && (reg_addr == STATUS_OFS);
    assign dec_req  = stat_wr && reg_wdata[DEC_BIT];
    assign sync_req = stat_wr && reg_wdata[SYNC_BIT];

    // Base register address decode.
    always_comb begin
        for (int i = 0; i < NUM_BASES; i++)
            base_wr[i] = reg_wen && (reg_addr == BASE_OFS + REG_AW'(4 * i));
    end

    // Blanking edge history for start-of-frame detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vblank_q <= 1'b0;
        else        vblank_q <= vblank;
    end

    assign sof_evt  = vblank && !vblank_q && (!interlaced || field_odd);
    assign fpe_next = vbi_en ? '0 : fifo_misalign;

    // Error flags reload at each event; irq marks newly set flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpe_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= sof_evt && |(fpe_next & ~fpe_q);
            if (sof_evt) fpe_q <= fpe_next;
        end
    end

    vcap_base_shadow #(.NUM_BASES(NUM_BASES), .BASE_W(BASE_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (base_wr),
        .wdata       (reg_wdata[BASE_W-1:0]),
        .sof         (sof_evt),
        .staged_flat (staged),
        .active_flat (active_base),
        .pending     (pending)
    );

    vcap_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pkt_rcvd),
        .dec   (dec_req),
        .count (pkt_cnt)
    );

    vcap_sync_pulse #(.PULSE_LEN(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sync_req),
        .pulse (sync_out)
    );

    assign brnu = |pending;

    // Status word assembly; strobes and reserved bits read 0.
    always_comb begin
        status_word = '0;
        status_word[CNT_LSB +: CNT_W]    = pkt_cnt;
        status_word[FPE_LSB +: NUM_FIFO] = fpe_q;
        status_word[PEND_BIT]            = brnu;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STATUS_OFS) reg_rdata = status_word;
        for (int i = 0; i < NUM_BASES; i++)
            if (reg_addr == BASE_OFS + REG_AW'(4 * i))
                reg_rdata = REG_DW'(staged[i*BASE_W +: BASE_W]);
    end
endmodule

// File: rtl/vcap_status_chk.sv
// Module: assertion checker for vcap_status, bound to every instance.
// Observes ports and internal strobes only; drives nothing.
module vcap_status_chk #(
    parameter int NUM_BASES = 4,
    parameter int BASE_W    = 32,
    parameter int CNT_W     = 8,
    parameter int SYNC_LEN  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        pkt_rcvd,
    input logic                        dec_req,
    input logic [CNT_W-1:0]            pkt_cnt,
    input logic                        sync_out,
    input logic                        sof_evt,
    input logic [NUM_BASES*BASE_W-1:0] active_base,
    input logic                        brnu,
    input logic [NUM_BASES-1:0]        base_wr,
    input logic                        irq,
    input logic [2:0]                  fpe_q
);
    localparam int HW = $clog2(SYNC_LEN + 2);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [HW-1:0] high_run;

    // Length of the current sync high run.
    always_ff @(posedge clk) begin
        if (!rst_n)        high_run <= '0;
        else if (sync_out) high_run <= high_run + 1'b1;
        else               high_run <= '0;
    end

    a_r7_cancel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_rcvd && dec_req) |=> $stable(pkt_cnt));

    a_r8_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == CMAX && pkt_rcvd && !dec_req) |=> (pkt_cnt == CMAX));

    a_r8_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == '0 && dec_req && !pkt_rcvd) |=> (pkt_cnt == '0));

    a_r3_active_moves_at_sof: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_base) |-> $past(sof_evt));

    a_r3_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && base_wr == '0) |=> !brnu);

    a_r10_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fpe_q != 3'b000));

    a_r11_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
        high_run <= HW'(SYNC_LEN));

    a_r11_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_out) |-> (high_run == HW'(SYNC_LEN)));
endmodule

bind vcap_status vcap_status_chk #(
    .NUM_BASES (NUM_BASES),
    .BASE_W    (BASE_W),
    .CNT_W     (CNT_W),
    .SYNC_LEN  (SYNC_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_rcvd    (pkt_rcvd),
    .dec_req     (dec_req),
    .pkt_cnt     (pkt_cnt),
    .sync_out    (sync_out),
    .sof_evt     (sof_evt),
    .active_base (active_base),
    .brnu        (brnu),
    .base_wr     (base_wr),
    .irq         (irq),
    .fpe_q       (fpe_q)
);

// File: tb/vcap_status_bench.sv
`timescale 1ns/1ps
// Bench for vcap_status: a counter vector table walked by one loop, then
// directed tests for reset, start-of-frame rules, flags, saturation and sync.
module vcap_status_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wen = 1'b0;
    logic [7:0]   reg_addr = 8'h00;
    logic [31:0]  reg_wdata = 32'h0;
    logic [31:0]  reg_rdata;
    logic         interlaced = 1'b1;
    logic         field_odd = 1'b0;
    logic         vblank = 1'b0;
    logic         vbi_en = 1'b0;
    logic         pkt_rcvd = 1'b0;
    logic [2:0]   fifo_misalign = 3'b000;
    logic [127:0] active_base;
    logic         irq;
    logic         sync_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] ST = 8'h08;

    // Vector: {pkt, dec, expected count}.
    localparam logic [9:0] VEC [16] = '{
        {1'b1,1'b0,8'd1}, {1'b1,1'b0,8'd2}, {1'b1,1'b0,8'd3}, {1'b1,1'b1,8'd3},
        {1'b0,1'b1,8'd2}, {1'b0,1'b0,8'd2}, {1'b1,1'b0,8'd3}, {1'b0,1'b1,8'd2},
        {1'b0,1'b1,8'd1}, {1'b0,1'b1,8'd0}, {1'b0,1'b1,8'd0}, {1'b1,1'b1,8'd0},
        {1'b1,1'b0,8'd1}, {1'b1,1'b1,8'd1}, {1'b1,1'b0,8'd2}, {1'b0,1'b1,8'd1}
    };

    always #2.5 clk = ~clk;

    vcap_status u_vcap_status (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .interlaced(interlaced),
        .field_odd(field_odd), .vblank(vblank), .vbi_en(vbi_en),
        .pkt_rcvd(pkt_rcvd), .fifo_misalign(fifo_misalign),
        .active_base(active_base), .irq(irq), .sync_out(sync_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    // Low then high on vblank; returns irq in the cycle after the edge.
    task automatic frame_edge(output logic irq_seen);
        @(negedge clk); vblank = 1'b0;
        @(negedge clk); vblank = 1'b1;
        @(negedge clk); irq_seen = irq;
    endtask

    function automatic logic [31:0] act_b(input int i);
        return active_base[i*32 +: 32];
    endfunction

    initial begin
        logic [31:0] d;
        logic        iq;
        int          hi;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state.
        rd(ST, d);            check("R6 status", d, 32'h0);
        check("R6 active", {31'b0, |active_base}, 32'h0);
        check("R6 irq/sync", {30'b0, irq, sync_out}, 32'h0);
        rd(8'h04, d);         check("R1 unmapped", d, 32'h0);

        // R7/R8: vector table walk on the counter.
        foreach (VEC[k]) begin
            @(negedge clk);
            pkt_rcvd = VEC[k][9];
            reg_wen = VEC[k][8]; reg_addr = ST; reg_wdata = 32'h0004_0000;
            @(negedge clk);
            pkt_rcvd = 1'b0; reg_wen = 1'b0;
            rd(ST, d);
            check($sformatf("R7/R8 vector %0d", k), {24'h0, d[31:24]}, {24'h0, VEC[k][7:0]});
        end

        // R12: writes to read-only fields are ignored (count 1, flags 0).
        wr(ST, 32'hFFF1_0000);
        rd(ST, d);            check("R12 ro fields", d, 32'h0100_0000);

        // R2: staging writes.
        wr(8'h10, 32'h1000_0000);
        wr(8'h18, 32'h0000_000A);
        rd(8'h10, d);         check("R2 readback", d, 32'h1000_0000);
        check("R2 active held", act_b(0), 32'h0);
        rd(ST, d);            check("R2 pending", {31'b0, d[16]}, 32'h1);

        // R4: even-field blanking edge does nothing.
        interlaced = 1'b1; field_odd = 1'b0;
        frame_edge(iq);
        check("R4 even no copy", act_b(0), 32'h0);
        rd(ST, d);            check("R4 even pending", {31'b0, d[16]}, 32'h1);

        // R4/R3/R9/R10: odd-field edge with flags B and Y.
        field_odd = 1'b1; fifo_misalign = 3'b101;
        frame_edge(iq);
        check("R4 odd copy b0", act_b(0), 32'h1000_0000);
        check("R4 odd copy b2", act_b(2), 32'h0000_000A);
        check("R10 irq rise", {31'b0, iq}, 32'h1);
        rd(ST, d);            check("R9 flags", {29'b0, d[22:20]}, 32'h5);
        check("R3 pending clear", {31'b0, d[16]}, 32'h0);
        @(negedge clk);       check("R10 irq one cycle", {31'b0, irq}, 32'h0);

        // R4: vblank held high, new write must stay pending.
        wr(8'h14, 32'h2222_0000);
        repeat (3) @(negedge clk);
        check("R4 held no copy", act_b(1), 32'h0);

        // R3/R10: progressive edge, same flags give no irq.
        interlaced = 1'b0; field_odd = 1'b0;
        frame_edge(iq);
        check("R3 progressive copy", act_b(1), 32'h2222_0000);
        check("R10 same flags no irq", {31'b0, iq}, 32'h0);

        // R9: vbi enabled forces flags to zero.
        vbi_en = 1'b1; fifo_misalign = 3'b111;
        frame_edge(iq);
        rd(ST, d);            check("R9 vbi zero", {29'b0, d[22:20]}, 32'h0);
        vbi_en = 1'b0; fifo_misalign = 3'b010;
        frame_edge(iq);
        rd(ST, d);            check("R9 flag R", {29'b0, d[22:20]}, 32'h2);
        check("R10 new flag irq", {31'b0, iq}, 32'h1);

        // R5: write in the same cycle as start-of-frame.
        wr(8'h1C, 32'hAAAA_0001);
        @(negedge clk); vblank = 1'b0;
        @(negedge clk); vblank = 1'b1;
        reg_wen = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'hBBBB_0002;
        @(negedge clk); reg_wen = 1'b0;
        check("R5 old value active", act_b(3), 32'hAAAA_0001);
        rd(ST, d);            check("R5 still pending", {31'b0, d[16]}, 32'h1);
        frame_edge(iq);
        check("R5 new value next", act_b(3), 32'hBBBB_0002);

        // R8: saturate high, cancel, then one decrement.
        @(negedge clk); pkt_rcvd = 1'b1;
        repeat (300) @(negedge clk);
        pkt_rcvd = 1'b0;
        rd(ST, d);            check("R8 sat 255", {24'h0, d[31:24]}, 32'hFF);
        @(negedge clk); pkt_rcvd = 1'b1;
        reg_wen = 1'b1; reg_addr = ST; reg_wdata = 32'h0004_0000;
        @(negedge clk); pkt_rcvd = 1'b0; reg_wen = 1'b0;
        rd(ST, d);            check("R7 cancel at 255", {24'h0, d[31:24]}, 32'hFF);
        wr(ST, 32'h0004_0000);
        rd(ST, d);            check("R7 dec", {24'h0, d[31:24]}, 32'hFE);
        check("R1 strobes read 0", {30'b0, d[18:17]}, 32'h0);

        // R11: 32-cycle pulse, retrigger at cycle 10 ignored.
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = ST; reg_wdata = 32'h0002_0000;
        @(negedge clk); reg_wen = 1'b0;
        hi = 0;
        while (sync_out && hi < 100) begin
            hi++;
            reg_wen = (hi == 10);
            @(negedge clk);
        end
        reg_wen = 1'b0;
        check("R11 pulse width", 32'(hi), 32'd32);
        repeat (3) @(negedge clk);
        check("R11 stays low", {31'b0, sync_out}, 32'h0);
        rd(ST, d);            check("R1 sync bit reads 0", {31'b0, d[17]}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule